// File: doc/BRIEF.md
# Sequencer Software Interrupt Flag Register

This block is a small 32-bit status register. An on-chip command sequencer uses it to raise any of four general-purpose interrupt flags. The register can be reached through two write paths. The sequencer path can set flags. The host serial-bus path reaches the same register, but its writes are dropped without any effect. Reads through the host path carry no flag information.

Software or interrupt-service logic removes pending flags through a dedicated clear strobe. This strobe is a separate input from the sequencer write path. The block drives one combined interrupt line. That line is registered and follows the OR of the pending flags one cycle later. The sequencer-side read image holds the flags in bits 3:0 and a fixed reserved one in bit 4, which gives a reset image of 0x00000010.

Top module: `seq_soft_irq_reg`

## Requirements
- R1: After a synchronous reset, all four flags are 0, `seq_rd_data` reads 0x00000010 and `irq` is 0.
- R2: On a clock edge where `seq_wr_en` is 1, each flag whose bit in `seq_wr_data[3:0]` is 1 becomes set. Zero bits in the write data leave their flags unchanged, so a sequencer write never clears a flag.
- R3: The four flags are independent. A flag changes only when its own set bit or its own clear bit is active. Bits 31:4 of any write data affect nothing.
- R4: A 1 in `clr_strobe[i]` clears flag i at the next edge, unless that flag is set in the same cycle. A 0 in a strobe bit leaves its flag as it was.
- R5: If flag i is set by the sequencer and cleared by `clr_strobe[i]` in the same cycle, the set takes priority and the flag is 1 afterwards.
- R6: A write through `host_wr_en`/`host_wr_data` changes no flag and never causes `irq` to be asserted.
- R7: `host_rd_data` is always 0x00000000, whatever the flag state.
- R8: `seq_rd_data` bits 3:0 hold the current flags, bit 4 is always 1, and bits 31:5 are always 0.
- R9: `irq` is registered. At every edge after reset it takes the OR of the flags that held before that edge, so it lags a flag change by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_wr_en | input | 1 | Sequencer write strobe |
| seq_wr_data | input | 32 | Sequencer write data; a 1 in bits 3:0 sets the matching flag |
| host_wr_en | input | 1 | Host serial-bus write strobe (dropped) |
| host_wr_data | input | 32 | Host serial-bus write data (dropped) |
| clr_strobe | input | 4 | Per-flag clear strobe, one bit per flag |
| seq_rd_data | output | 32 | Register image seen by the sequencer |
| host_rd_data | output | 32 | Host read data, always zero |
| irq | output | 1 | Registered OR of all pending flags |

## Verification
A sequencer set and a clear strobe can land on the same flag in one cycle, and a host write can arrive in the same cycle as either of them. The bench provokes these coincidences on purpose. It sets and clears the same bit at once, and it issues host writes with all bits set together with clears and together with sequencer sets. In each case it checks that the set wins, that the host write adds nothing, and that `irq` follows the surviving flags one cycle later. A behavioural model updated on every clock judges the same cases under a long run of mixed random traffic.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int DATA_W      = 32;
    localparam int NUM_FLAGS   = 4;
    localparam int RSV_ONE_POS = 4;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
    typedef logic [DATA_W-1:0]    word_t;

    typedef enum logic [0:0] {
        SRC_SEQ  = 1'b0,
        SRC_HOST = 1'b1
    } wr_src_e;

    typedef struct packed {
        logic    valid;
        wr_src_e src;
        word_t   data;
    } wr_req_t;

    function automatic word_t read_image(flag_vec_t f);
        word_t r;
        r = '0;
        r[RSV_ONE_POS] = 1'b1;
        r[NUM_FLAGS-1:0] = f;
        return r;
    endfunction

endpackage

// File: rtl/sirq_port_gate.sv
module sirq_port_gate
    import sirq_pkg::*;
(
    input  logic      seq_wr_en,
    input  word_t     seq_wr_data,
    input  logic      host_wr_en,
    input  word_t     host_wr_data,
    output flag_vec_t set_mask
);

    wr_req_t req;
    logic    unused_rsv_bits;

    always_comb begin
        req = '0;
        if (seq_wr_en) begin
            req.valid = 1'b1;
            req.src   = SRC_SEQ;
            req.data  = seq_wr_data;
        end else if (host_wr_en) begin
            req.valid = 1'b1;
            req.src   = SRC_HOST;
            req.data  = host_wr_data;
        end
    end

    assign set_mask = (req.valid && req.src == SRC_SEQ) ? req.data[NUM_FLAGS-1:0] : '0;
    assign unused_rsv_bits = ^req.data[DATA_W-1:NUM_FLAGS];

endmodule

// File: rtl/sirq_flag_bank.sv
module sirq_flag_bank
    import sirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_mask,
    input  flag_vec_t clr_mask,
    output flag_vec_t flags
);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (set_mask[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                flags[i] <= 1'b0;
            end
        end

        assert_set_R2: assert property (@(posedge clk) disable iff (rst)
            set_mask[i] |=> flags[i]);

        assert_clr_R4: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[i] && !set_mask[i]) |=> !flags[i]);

        assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[i] && set_mask[i]) |=> flags[i]);

        assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (!clr_mask[i] && !set_mask[i]) |=> $stable(flags[i]));
    end

endmodule

// File: rtl/sirq_irq_reg.sv
module sirq_irq_reg
    import sirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t flags,
    output logic      irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |flags;
        end
    end

    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq == $past(|flags)));

endmodule

// File: rtl/seq_soft_irq_reg.sv
module seq_soft_irq_reg
    import sirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seq_wr_en,
    input  logic [DATA_W-1:0]    seq_wr_data,
    input  logic                 host_wr_en,
    input  logic [DATA_W-1:0]    host_wr_data,
    input  logic [NUM_FLAGS-1:0] clr_strobe,
    output logic [DATA_W-1:0]    seq_rd_data,
    output logic [DATA_W-1:0]    host_rd_data,
    output logic                 irq
);

    flag_vec_t set_mask;
    flag_vec_t flags;

    sirq_port_gate u_gate (
        .seq_wr_en    (seq_wr_en),
        .seq_wr_data  (seq_wr_data),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .set_mask     (set_mask)
    );

    sirq_flag_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (clr_strobe),
        .flags    (flags)
    );

    sirq_irq_reg u_irq (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .irq   (irq)
    );

    assign seq_rd_data  = read_image(flags);
    assign host_rd_data = '0;

    assert_host_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && !seq_wr_en && clr_strobe == '0) |=> $stable(seq_rd_data));

    assert_host_noirq_R6: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && !seq_wr_en && seq_rd_data[NUM_FLAGS-1:0] == '0) |=> (seq_rd_data[NUM_FLAGS-1:0] == '0));

endmodule

// File: tb/seq_soft_irq_reg_tb.sv
module seq_soft_irq_reg_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        seq_wr_en;
    logic [31:0] seq_wr_data;
    logic        host_wr_en;
    logic [31:0] host_wr_data;
    logic [3:0]  clr_strobe;
    logic [31:0] seq_rd_data;
    logic [31:0] host_rd_data;
    logic        irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [3:0] m_flags;
    logic       m_irq;

    always #2.5 clk = ~clk;

    seq_soft_irq_reg u_dut (
        .clk          (clk),
        .rst          (rst),
        .seq_wr_en    (seq_wr_en),
        .seq_wr_data  (seq_wr_data),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .clr_strobe   (clr_strobe),
        .seq_rd_data  (seq_rd_data),
        .host_rd_data (host_rd_data),
        .irq          (irq)
    );

    // Behavioural reference: set beats clear, host ignored, irq lags one cycle.
    always @(posedge clk) begin
        if (rst) begin
            m_flags <= 4'h0;
            m_irq   <= 1'b0;
        end else begin
            m_irq   <= (m_flags != 4'h0);
            m_flags <= (m_flags & ~clr_strobe) | (seq_wr_en ? seq_wr_data[3:0] : 4'h0);
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, 2 ns after the edge.
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            check(seq_rd_data === {27'd0, 1'b1, m_flags}, "R2 R3 R4 R5 R6 R8 model image", seq_rd_data, {27'd0, 1'b1, m_flags});
            check(irq === m_irq, "R9 model irq", {31'd0, irq}, {31'd0, m_irq});
            check(host_rd_data === 32'h0, "R7 host read", host_rd_data, 32'h0);
        end
    end

    task automatic drive(input bit sw, input logic [31:0] sd, input bit hw, input logic [31:0] hd, input logic [3:0] cl);
        @(negedge clk);
        seq_wr_en = sw; seq_wr_data = sd;
        host_wr_en = hw; host_wr_data = hd;
        clr_strobe = cl;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        drive(1'b0, 32'h0, 1'b0, 32'h0, 4'h0);
    endtask

    initial begin
        rst = 1'b1;
        seq_wr_en = 1'b0; seq_wr_data = '0;
        host_wr_en = 1'b0; host_wr_data = '0;
        clr_strobe = '0;
        repeat (3) @(posedge clk);
        #2;
        check(seq_rd_data === 32'h10, "R1 reset image", seq_rd_data, 32'h10);
        check(irq === 1'b0, "R1 reset irq", {31'd0, irq}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2: set flag 1, upper bits ignored (R3)
        drive(1'b1, 32'hFFFF_FFF2, 1'b0, 32'h0, 4'h0);
        check(seq_rd_data === 32'h12, "R2 set bit1", seq_rd_data, 32'h12);
        check(irq === 1'b0, "R9 irq lags set", {31'd0, irq}, 32'h0);
        // R2: zero write leaves flag
        drive(1'b1, 32'h0000_0008, 1'b0, 32'h0, 4'h0);
        check(seq_rd_data === 32'h1A, "R2 write keeps bit1", seq_rd_data, 32'h1A);
        check(irq === 1'b1, "R9 irq after set", {31'd0, irq}, 32'h1);
        // R4: clear bit3 only
        drive(1'b0, 32'h0, 1'b0, 32'h0, 4'h8);
        check(seq_rd_data === 32'h12, "R4 clear bit3", seq_rd_data, 32'h12);
        // R5: set and clear bit0 together, clear bit1
        drive(1'b1, 32'h1, 1'b0, 32'h0, 4'h3);
        check(seq_rd_data === 32'h11, "R5 set wins bit0", seq_rd_data, 32'h11);
        // R6: host write all ones with a clear of bit0
        drive(1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF, 4'h1);
        check(seq_rd_data === 32'h10, "R6 host write with clear", seq_rd_data, 32'h10);
        check(irq === 1'b1, "R9 irq still old", {31'd0, irq}, 32'h1);
        idle();
        check(irq === 1'b0, "R9 irq drops", {31'd0, irq}, 32'h0);
        // R6: host-only write while empty
        drive(1'b0, 32'h0, 1'b1, 32'h0000_000F, 4'h0);
        idle();
        check(seq_rd_data === 32'h10, "R6 host write ignored", seq_rd_data, 32'h10);
        check(irq === 1'b0, "R6 host no irq", {31'd0, irq}, 32'h0);
        // R6: host together with seq set
        drive(1'b1, 32'h4, 1'b1, 32'hF, 4'h0);
        check(seq_rd_data === 32'h14, "R6 host beside seq", seq_rd_data, 32'h14);
        check(host_rd_data === 32'h0, "R7 host read with flag", host_rd_data, 32'h0);
        check(seq_rd_data[31:5] === 27'd0 && seq_rd_data[4] === 1'b1, "R8 reserved bits", seq_rd_data, 32'h14);

        for (int n = 0; n < 400; n++) begin
            drive(1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 1)), $urandom, 4'($urandom));
        end

        rst = 1'b1;
        idle();
        check(seq_rd_data === 32'h10, "R1 re-reset image", seq_rd_data, 32'h10);
        check(irq === 1'b0, "R1 re-reset irq", {31'd0, irq}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule